// File: doc/BRIEF.md
# Interrupt Source Emulation Front End

This block is the first stage of the main interrupt group of an interrupt controller. It takes seventeen raw interrupt source lines and merges each one with a bit that software can write. The merged request then passes through the same path a real request would take. Three of the sources are external IRQ pins. Each pin has its own sense setting: level high, level low, rising edge or falling edge. Edge events are held in a status bit until software clears that bit.

Every source has a mask bit. A masked source cannot reach the combined interrupt request. The combined request is registered, so it changes one clock after any change at a source, in the emulation register or in the mask. Software can therefore raise any interrupt without touching the peripheral that owns it, and exercise the interrupt service path that way.

There is one exception. Source 4 is an aggregated peripheral line. Its peripheral flag output follows only the real input, never the injected bit.

Top module: `irq_emu_front`

## Requirements
- R1: After reset the emulation word reads 0x00000000, the mask word reads 0x0001FFFF (all seventeen sources masked), the sense word reads 0, the status word reads 0, and both irq_o and periph_o are 0.
- R2: In the emulation, mask and status words, source i sits at bus bit 16-i, so source 0 is bit 16 and source 16 is bit 0. Bits 31:17 of these words, and bits 31:6 of the sense word, read as zero. Writes to those bits are ignored.
- R3: The effective request of each source is its raw input ORed with its emulation bit. A source in level-high sense shows that effective value in the status word in the same cycle.
- R4: A source whose mask bit is 1 never drives irq_o. irq_o is 1 when some status bit is 1 while its mask bit is 0.
- R5: irq_o is registered. It changes exactly one clock edge after the change in source, emulation or mask that causes it.
- R6: IRQ pin k (k = 1..3, which is source k) takes its sense from sense-word bits [2k-1:2k-2]. The codes are 00 level high, 01 rising edge, 10 falling edge and 11 level low. In level low, status is the inverse of the effective request.
- R7: In an edge sense, an edge of the effective request sets the status bit. This includes an edge made by setting or clearing the emulation bit. The status bit stays set after the request returns, until software clears it.
- R8: periph_o is the raw source 4 input registered by one clock. Setting emulation bit 4 never raises periph_o, even though it does raise status bit 12.
- R9: Writing 1 to a status bit clears a held edge event. In the same cycle, a new edge takes precedence over the clear. Writing to the status bit of a source in a level sense has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word select: 0 emulation, 1 mask, 2 sense, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| src_i | input | 17 | Raw source inputs, already synchronous to clk |
| irq_o | output | 1 | Registered combined interrupt request |
| periph_o | output | 1 | Registered flag for the real aggregated peripheral input |

## Verification
Register writes land on the clock edge that follows the strobe. The status word can be read back in the low phase right after that edge, because a level source, or an edge seen in that cycle, appears in status combinationally. irq_o and periph_o are due one edge later. For these two outputs the bench checks the old value in the same low phase, then checks the new value in the next low phase, which catches both a missing register and an extra one. Every input is driven on a falling edge, and every result is sampled 5 ns later, so no comparison depends on the order in which processes run at a rising edge.

// File: rtl/irq_emu_pkg.sv
package irq_emu_pkg;

    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 4;
    localparam int NUM_SRC    = 17;
    localparam int IRQ_FIRST  = 1;
    localparam int NUM_IRQ    = 3;
    localparam int PERIPH_IDX = 4;
    localparam int SENSE_W    = 2 * NUM_IRQ;

    localparam logic [ADDR_W-1:0] REG_EMU   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] REG_MASK  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] REG_SENSE = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] REG_STAT  = ADDR_W'(3);

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'b00,
        SENSE_RISE   = 2'b01,
        SENSE_FALL   = 2'b10,
        SENSE_LVL_LO = 2'b11
    } sense_e;

    typedef struct packed {
        src_vec_t             emu;
        src_vec_t             mask;
        logic [SENSE_W-1:0]   sense;
    } ctrl_regs_t;

    // Source i occupies bus bit NUM_SRC-1-i (source 0 is the highest used bit).
    function automatic logic [BUS_W-1:0] vec_to_word(src_vec_t v);
        logic [BUS_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            w[NUM_SRC-1-i] = v[i];
        end
        return w;
    endfunction

    function automatic src_vec_t word_to_vec(logic [BUS_W-1:0] w);
        src_vec_t v;
        for (int i = 0; i < NUM_SRC; i++) begin
            v[i] = w[NUM_SRC-1-i];
        end
        return v;
    endfunction

    function automatic sense_e sense_of(logic [SENSE_W-1:0] s, int pin);
        return sense_e'(s[2*pin +: 2]);
    endfunction

endpackage

// File: rtl/irq_emu_regs.sv
module irq_emu_regs
    import irq_emu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  src_vec_t           status_i,
    output ctrl_regs_t         ctrl_o,
    output src_vec_t           stat_clr_o,
    output logic [BUS_W-1:0]   bus_rdata
);

    ctrl_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.emu   <= '0;
            regs_q.mask  <= '1;
            regs_q.sense <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                REG_EMU:   regs_q.emu   <= word_to_vec(bus_wdata);
                REG_MASK:  regs_q.mask  <= word_to_vec(bus_wdata);
                REG_SENSE: regs_q.sense <= bus_wdata[SENSE_W-1:0];
                default:   ;
            endcase
        end
    end

    assign ctrl_o     = regs_q;
    assign stat_clr_o = (bus_we && bus_addr == REG_STAT) ? word_to_vec(bus_wdata) : '0;

    always_comb begin
        case (bus_addr)
            REG_EMU:   bus_rdata = vec_to_word(regs_q.emu);
            REG_MASK:  bus_rdata = vec_to_word(regs_q.mask);
            REG_SENSE: bus_rdata = BUS_W'(regs_q.sense);
            REG_STAT:  bus_rdata = vec_to_word(status_i);
            default:   bus_rdata = '0;
        endcase
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs_q.emu == '0 && regs_q.mask == '1 && regs_q.sense == '0)); // R1

endmodule

// File: rtl/irq_emu_detect.sv
module irq_emu_detect
    import irq_emu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   src_i,
    input  ctrl_regs_t ctrl_i,
    input  src_vec_t   stat_clr_i,
    output src_vec_t   status_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic eff;
        logic prev_q;

        // Injected bit merges before any sense logic, as a pin would.
        assign eff = src_i[i] | ctrl_i.emu[i];

        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= eff;
        end

        if (i >= IRQ_FIRST && i < IRQ_FIRST + NUM_IRQ) begin : g_pin
            sense_e mode;
            logic   is_edge;
            logic   edge_now;
            logic   latch_q;

            assign mode = sense_of(ctrl_i.sense, i - IRQ_FIRST);

            always_comb begin
                case (mode)
                    SENSE_RISE: begin is_edge = 1'b1; edge_now = eff & ~prev_q; end
                    SENSE_FALL: begin is_edge = 1'b1; edge_now = ~eff & prev_q; end
                    default:    begin is_edge = 1'b0; edge_now = 1'b0;          end
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst)           latch_q <= 1'b0;
                else if (!is_edge) latch_q <= 1'b0;
                else               latch_q <= (latch_q & ~stat_clr_i[i]) | edge_now;
            end

            always_comb begin
                case (mode)
                    SENSE_LVL_HI: status_o[i] = eff;
                    SENSE_LVL_LO: status_o[i] = ~eff;
                    default:      status_o[i] = latch_q | edge_now;
                endcase
            end

            AST_EDGE_HELD: assert property (@(posedge clk) disable iff (rst)
                (latch_q && is_edge && !stat_clr_i[i]) |=> latch_q); // R7
        end else begin : g_lvl
            assign status_o[i] = eff;
        end
    end

endmodule

// File: rtl/irq_emu_front.sv
module irq_emu_front
    import irq_emu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o,
    output logic               periph_o
);

    ctrl_regs_t ctrl;
    src_vec_t   stat_clr;
    src_vec_t   status;
    logic       irq_q;
    logic       periph_q;

    irq_emu_regs i_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .status_i   (status),
        .ctrl_o     (ctrl),
        .stat_clr_o (stat_clr),
        .bus_rdata  (bus_rdata)
    );

    irq_emu_detect i_detect (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .ctrl_i     (ctrl),
        .stat_clr_i (stat_clr),
        .status_o   (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q    <= 1'b0;
            periph_q <= 1'b0;
        end else begin
            irq_q    <= |(status & ~ctrl.mask);
            periph_q <= src_i[PERIPH_IDX];
        end
    end

    assign irq_o    = irq_q;
    assign periph_o = periph_q;

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&ctrl.mask) |=> !irq_o); // R4

    AST_PERIPH_REAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        !src_i[PERIPH_IDX] |=> !periph_o); // R8

    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |=> !irq_o); // R5

endmodule

// File: tb/test_irq_emu_front.sv
module test_irq_emu_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [16:0] src_i = '0;
    logic        irq_o;
    logic        periph_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];
    event        pushed;

    always #10 clk = ~clk;

    irq_emu_front i_irq_emu_front (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
        .irq_o(irq_o), .periph_o(periph_o)
    );

    // Monitor: drains the scoreboard as the driver posts results.
    initial begin
        forever begin
            @(pushed);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                logic [31:0] e;
                logic [31:0] a;
                string t;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s actual=0x%08h expected=0x%08h", t, a, e);
                end
            end
        end
    end

    task automatic post(input logic [31:0] act, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        act_q.push_back(act);
        -> pushed;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #5;
        post(bus_rdata, exp, tag);
        @(negedge clk);
    endtask

    task automatic pin(input logic [31:0] exp, input logic sig, input string tag);
        #5;
        post({31'b0, sig}, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(0, 32'h0, "R1 emu reset");
        rd(1, 32'h0001FFFF, "R1 mask reset");
        rd(2, 32'h0, "R1 sense reset");
        rd(3, 32'h0, "R1 status reset");
        pin(0, irq_o, "R1 irq reset");
        pin(0, periph_o, "R1 periph reset");

        wr(0, 32'hFFFFFFFF);
        rd(0, 32'h0001FFFF, "R2 emu reserved bits zero");
        rd(3, 32'h0001FFFF, "R3 injected level status");
        pin(0, irq_o, "R4 all masked no irq");
        pin(0, periph_o, "R8 injected all no periph");
        wr(0, 32'hFFFE0000);
        rd(0, 32'h0, "R2 reserved write ignored");
        wr(2, 32'hFFFFFFC0);
        rd(2, 32'h0, "R2 sense reserved ignored");

        wr(1, 32'h0001FFFE);
        @(negedge clk);
        src_i[16] = 1'b1;
        pin(0, irq_o, "R5 irq not yet");
        rd(3, 32'h00000001, "R3 raw source 16 at bit 0");
        pin(1, irq_o, "R5 irq one edge later");
        @(negedge clk);
        src_i[16] = 1'b0;
        pin(1, irq_o, "R5 irq holds before edge");
        @(negedge clk);
        pin(0, irq_o, "R5 irq drops");

        wr(1, 32'h0000FFFF);
        wr(0, 32'h00010000);
        pin(0, irq_o, "R5 emu src0 not yet");
        @(negedge clk);
        pin(1, irq_o, "R4 unmasked injected src0");
        wr(1, 32'h0001FFFF);
        @(negedge clk);
        pin(0, irq_o, "R4 remasked");
        wr(0, 32'h0);

        wr(2, 32'h00000001);
        wr(1, 32'h00017FFF);
        wr(0, 32'h00008000);
        rd(3, 32'h00008000, "R7 rising edge from emu");
        pin(1, irq_o, "R7 edge drives irq");
        wr(0, 32'h0);
        rd(3, 32'h00008000, "R7 edge held after release");
        wr(3, 32'h00008000);
        rd(3, 32'h0, "R9 write one clears edge");
        pin(0, irq_o, "R9 irq drops after clear");
        wr(1, 32'h0001FFFF);

        wr(2, 32'h00000008);
        src_i[2] = 1'b1;
        @(negedge clk);
        rd(3, 32'h0, "R6 falling sense ignores rise");
        src_i[2] = 1'b0;
        rd(3, 32'h00004000, "R6 falling edge seen");
        rd(3, 32'h00004000, "R7 falling edge held");
        wr(3, 32'h00004000);
        rd(3, 32'h0, "R9 falling cleared");

        wr(2, 32'h00000030);
        rd(3, 32'h00002000, "R6 level low active");
        wr(3, 32'h00002000);
        rd(3, 32'h00002000, "R9 clear ignored on level");
        src_i[3] = 1'b1;
        rd(3, 32'h0, "R6 level low idle");
        src_i[3] = 1'b0;
        wr(2, 32'h0);

        wr(1, 32'h0001EFFF);
        wr(0, 32'h00001000);
        rd(3, 32'h00001000, "R3 injected peripheral status");
        pin(0, periph_o, "R8 injected periph no flag");
        pin(1, irq_o, "R8 injected periph irq");
        wr(0, 32'h0);
        @(negedge clk);
        src_i[4] = 1'b1;
        pin(0, periph_o, "R8 periph before edge");
        @(negedge clk);
        pin(1, periph_o, "R8 periph after edge");
        src_i[4] = 1'b0;

        #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule